// File: doc/BRIEF.md
# Trap Return Status Sequencer

This block carries out the two trap-return operations of a RISC-V style core: the supervisor return (SRET) and the machine return (MRET). The core may include the hypervisor extension. The decoder hands the block a single-cycle request together with the following inputs:

- the current privilege and virtualization mode;
- the machine status word and the hypervisor status word;
- both saved exception PCs;
- the number of configured memory-protection rules.

One clock edge later the block returns one of two results. The first is an exception with its cause code. The second is the rewritten status words, the new privilege, the new virtualization bit and the PC the fetch unit must jump to.

The legality checks run in a fixed order: the privilege test first, then the alignment of the return target, then the trap-control bits. When a check fails, the status outputs repeat the sampled inputs, so the CSR file may write them back without changing anything. A successful return that enters virtualized mode from the hypervisor pulses a request to swap the hypervisor register bank. The swap itself is done elsewhere.

Top module: `trap_ret_seq`

## Requirements
- R1: While rst_ni is low, and after it rises with no request, done_o, exc_o and swap_o are 0, and priv_o is 3 (machine), virt_o is 0 and cause_o is 0.
- R2: A request on req_valid_i yields exactly one done_o pulse on the following clock edge. Back-to-back requests yield back-to-back results in order, and done_o is 0 in any cycle after a cycle without a request.
- R3: An SRET issued at user privilege (privilege code 0; supervisor is 1, machine is 3) raises exc_o with cause 2 (illegal instruction).
- R4: With compressed support absent (HAS_C = 0), a return whose target PC (sepc_i for SRET, mepc_i for MRET) has a nonzero value in bits 1:0 raises cause 0 (misaligned target).
- R5: An SRET below machine privilege with the trap-SRET bit (mstat_i bit 22) set raises cause 2. At machine privilege that bit has no effect.
- R6: With the hypervisor present, an SRET while virt_i is 1 and the virtual trap-SRET bit (hstat_i bit 22) is 1 raises cause 22 (virtual instruction). With virt_i at 0 that bit has no effect.
- R7: An MRET below machine privilege raises cause 2. It also raises cause 2 when pmp_rules_i is 0 and the previous machine mode field (mstat_i bits 12:11) is not 3.
- R8: When several checks fail at once, the cause reported follows this priority: privilege, then alignment, then the trap-control and protection-rule checks.
- R9: A successful SRET sets priv_o to {0, SPP}. In mstat_o it copies SPIE into SIE, sets SPIE to 1, clears SPP and leaves every other bit unchanged. ret_pc_o is sepc_i. Field positions in mstat: SIE 1, MIE 3, SPIE 5, MPIE 7, SPP 8, MPP 12:11, MPV 39.
- R10: A successful SRET with virt_i at 0 sets virt_o to the SPV bit (hstat_i bit 7), clears SPV in hstat_o and pulses swap_o when SPV was 1. With virt_i at 1, virt_o stays 1, hstat_o equals hstat_i and swap_o stays 0.
- R11: A successful MRET sets priv_o to the old MPP and virt_o to the old MPV. It copies MPIE into MIE, sets MPIE to 1, and clears MPP and MPV. It pulses swap_o when MPV was 1, and ret_pc_o is mepc_i.
- R12: On an exception, mstat_o, hstat_o, priv_o and virt_o repeat the sampled inputs, and swap_o and ret_pc_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Single-cycle return request |
| req_is_mret_i | input | 1 | 1 selects MRET, 0 selects SRET |
| priv_i | input | 2 | Current privilege (0 user, 1 supervisor, 3 machine) |
| virt_i | input | 1 | Current virtualization mode |
| mstat_i | input | XLEN | Machine status word |
| hstat_i | input | XLEN | Hypervisor status word |
| sepc_i | input | XLEN | Supervisor saved exception PC |
| mepc_i | input | XLEN | Machine saved exception PC |
| pmp_rules_i | input | PMP_W | Number of configured protection rules |
| done_o | output | 1 | Result valid, one cycle after the request |
| exc_o | output | 1 | The return raised an exception |
| cause_o | output | 5 | Exception cause (0, 2 or 22) |
| mstat_o | output | XLEN | Updated machine status word |
| hstat_o | output | XLEN | Updated hypervisor status word |
| priv_o | output | 2 | New privilege |
| virt_o | output | 1 | New virtualization mode |
| ret_pc_o | output | XLEN | Return target PC |
| swap_o | output | 1 | Pulse requesting a hypervisor register-bank swap |

## Verification
The stimulus first checks each legality rule on its own: user-mode SRET, misaligned targets, the trap-SRET bit at supervisor and at machine level, the virtual trap bit with virtualization on and off, and MRET with and without protection rules. It then sets pairs of failing conditions together, which separates a correct priority order from a swapped one. Successful returns use opposite field values (SPIE set with SIE clear and the reverse, SPV and MPV both 0 and 1). This catches fields that are copied from the wrong place, fields that are never cleared, and a swap pulse that fires at the wrong time. Untouched background bits in both status words reveal any unintended write.

// File: rtl/trap_ret_pkg.sv
package trap_ret_pkg;

  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;

  localparam int unsigned CAUSE_W = 5;
  localparam logic [CAUSE_W-1:0] CAUSE_MISALIGN = 5'd0;
  localparam logic [CAUSE_W-1:0] CAUSE_ILLEGAL  = 5'd2;
  localparam logic [CAUSE_W-1:0] CAUSE_VIRT     = 5'd22;

  // machine status field positions
  localparam int unsigned MS_SIE    = 1;
  localparam int unsigned MS_MIE    = 3;
  localparam int unsigned MS_SPIE   = 5;
  localparam int unsigned MS_MPIE   = 7;
  localparam int unsigned MS_SPP    = 8;
  localparam int unsigned MS_MPP_LO = 11;
  localparam int unsigned MS_MPP_HI = 12;
  localparam int unsigned MS_TSR    = 22;
  localparam int unsigned MS_MPV    = 39;

  // hypervisor status field positions
  localparam int unsigned HS_SPV    = 7;
  localparam int unsigned HS_VTSR   = 22;

  typedef struct packed {
    logic               fault;
    logic [CAUSE_W-1:0] cause;
  } chk_res_t;

endpackage

// File: rtl/trap_ret_check.sv
module trap_ret_check
  import trap_ret_pkg::*;
#(
  parameter bit          HAS_HYP = 1'b1,
  parameter bit          HAS_C   = 1'b0,
  parameter int unsigned PMP_W   = 7
) (
  input  logic             is_mret_i,
  input  logic [1:0]       priv_i,
  input  logic             virt_i,
  input  logic             tsr_i,
  input  logic             vtsr_i,
  input  logic [1:0]       mpp_i,
  input  logic [1:0]       tgt_lo_i,
  input  logic [PMP_W-1:0] pmp_rules_i,
  output chk_res_t         res_o
);

  logic misal;
  logic sret_priv_bad, mret_priv_bad;
  logic sret_tsr_bad, sret_vtsr_bad, mret_pmp_bad;

  generate
    if (HAS_C) begin : g_c
      logic unused_lo;
      assign unused_lo = ^tgt_lo_i;
      assign misal     = 1'b0;
    end else begin : g_noc
      assign misal = |tgt_lo_i;
    end
    if (HAS_HYP) begin : g_hyp
      assign sret_vtsr_bad = virt_i & vtsr_i;
    end else begin : g_nohyp
      logic unused_h;
      assign unused_h      = virt_i ^ vtsr_i;
      assign sret_vtsr_bad = 1'b0;
    end
  endgenerate

  assign sret_priv_bad = (priv_i == PRIV_U);
  assign mret_priv_bad = (priv_i != PRIV_M);
  assign sret_tsr_bad  = tsr_i & (priv_i != PRIV_M);
  assign mret_pmp_bad  = (pmp_rules_i == '0) & (mpp_i != PRIV_M);

  // priority: privilege, alignment, control bits
  always_comb begin
    res_o = '{fault: 1'b0, cause: CAUSE_MISALIGN};
    if (is_mret_i) begin
      if (mret_priv_bad)     res_o = '{fault: 1'b1, cause: CAUSE_ILLEGAL};
      else if (misal)        res_o = '{fault: 1'b1, cause: CAUSE_MISALIGN};
      else if (mret_pmp_bad) res_o = '{fault: 1'b1, cause: CAUSE_ILLEGAL};
    end else begin
      if (sret_priv_bad)      res_o = '{fault: 1'b1, cause: CAUSE_ILLEGAL};
      else if (misal)         res_o = '{fault: 1'b1, cause: CAUSE_MISALIGN};
      else if (sret_tsr_bad)  res_o = '{fault: 1'b1, cause: CAUSE_ILLEGAL};
      else if (sret_vtsr_bad) res_o = '{fault: 1'b1, cause: CAUSE_VIRT};
    end
  end

endmodule

// File: rtl/trap_ret_update.sv
module trap_ret_update
  import trap_ret_pkg::*;
#(
  parameter int unsigned XLEN    = 64,
  parameter bit          HAS_HYP = 1'b1
) (
  input  logic            is_mret_i,
  input  logic            virt_i,
  input  logic [XLEN-1:0] mstat_i,
  input  logic [XLEN-1:0] hstat_i,
  output logic [XLEN-1:0] mstat_o,
  output logic [XLEN-1:0] hstat_o,
  output logic [1:0]      priv_o,
  output logic            virt_o,
  output logic            swap_o
);

  logic hyp_sret_path, hyp_mret_path;

  generate
    if (HAS_HYP) begin : g_hyp
      assign hyp_sret_path = ~virt_i;
      assign hyp_mret_path = 1'b1;
    end else begin : g_nohyp
      assign hyp_sret_path = 1'b0;
      assign hyp_mret_path = 1'b0;
    end
  endgenerate

  always_comb begin
    mstat_o = mstat_i;
    hstat_o = hstat_i;
    virt_o  = virt_i;
    swap_o  = 1'b0;
    if (is_mret_i) begin
      priv_o                       = mstat_i[MS_MPP_HI:MS_MPP_LO];
      mstat_o[MS_MIE]              = mstat_i[MS_MPIE];
      mstat_o[MS_MPIE]             = 1'b1;
      mstat_o[MS_MPP_HI:MS_MPP_LO] = PRIV_U;
      mstat_o[MS_MPV]              = 1'b0;
      if (hyp_mret_path) begin
        virt_o = mstat_i[MS_MPV];
        swap_o = mstat_i[MS_MPV];
      end
    end else begin
      priv_o           = {1'b0, mstat_i[MS_SPP]};
      mstat_o[MS_SIE]  = mstat_i[MS_SPIE];
      mstat_o[MS_SPIE] = 1'b1;
      mstat_o[MS_SPP]  = 1'b0;
      if (hyp_sret_path) begin
        virt_o          = hstat_i[HS_SPV];
        swap_o          = hstat_i[HS_SPV];
        hstat_o[HS_SPV] = 1'b0;
      end
    end
  end

endmodule

// File: rtl/trap_ret_seq.sv
module trap_ret_seq
  import trap_ret_pkg::*;
#(
  parameter int unsigned XLEN    = 64,
  parameter bit          HAS_HYP = 1'b1,
  parameter bit          HAS_C   = 1'b0,
  parameter int unsigned PMP_W   = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic             req_is_mret_i,
  input  logic [1:0]       priv_i,
  input  logic             virt_i,
  input  logic [XLEN-1:0]  mstat_i,
  input  logic [XLEN-1:0]  hstat_i,
  input  logic [XLEN-1:0]  sepc_i,
  input  logic [XLEN-1:0]  mepc_i,
  input  logic [PMP_W-1:0] pmp_rules_i,
  output logic             done_o,
  output logic             exc_o,
  output logic [4:0]       cause_o,
  output logic [XLEN-1:0]  mstat_o,
  output logic [XLEN-1:0]  hstat_o,
  output logic [1:0]       priv_o,
  output logic             virt_o,
  output logic [XLEN-1:0]  ret_pc_o,
  output logic             swap_o
);

  logic [XLEN-1:0] tgt_pc;
  chk_res_t        chk;
  logic [XLEN-1:0] mstat_n, hstat_n;
  logic [1:0]      priv_n;
  logic            virt_n, swap_n;

  assign tgt_pc = req_is_mret_i ? mepc_i : sepc_i;

  trap_ret_check #(
    .HAS_HYP(HAS_HYP), .HAS_C(HAS_C), .PMP_W(PMP_W)
  ) u_check (
    .is_mret_i   (req_is_mret_i),
    .priv_i      (priv_i),
    .virt_i      (virt_i),
    .tsr_i       (mstat_i[MS_TSR]),
    .vtsr_i      (hstat_i[HS_VTSR]),
    .mpp_i       (mstat_i[MS_MPP_HI:MS_MPP_LO]),
    .tgt_lo_i    (tgt_pc[1:0]),
    .pmp_rules_i (pmp_rules_i),
    .res_o       (chk)
  );

  trap_ret_update #(
    .XLEN(XLEN), .HAS_HYP(HAS_HYP)
  ) u_update (
    .is_mret_i (req_is_mret_i),
    .virt_i    (virt_i),
    .mstat_i   (mstat_i),
    .hstat_i   (hstat_i),
    .mstat_o   (mstat_n),
    .hstat_o   (hstat_n),
    .priv_o    (priv_n),
    .virt_o    (virt_n),
    .swap_o    (swap_n)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o   <= 1'b0;
      exc_o    <= 1'b0;
      cause_o  <= '0;
      mstat_o  <= '0;
      hstat_o  <= '0;
      priv_o   <= PRIV_M;
      virt_o   <= 1'b0;
      ret_pc_o <= '0;
      swap_o   <= 1'b0;
    end else begin
      done_o <= req_valid_i;
      swap_o <= 1'b0;
      if (req_valid_i) begin
        exc_o   <= chk.fault;
        cause_o <= chk.fault ? chk.cause : '0;
        if (chk.fault) begin
          // nothing commits: echo the sampled state
          mstat_o  <= mstat_i;
          hstat_o  <= hstat_i;
          priv_o   <= priv_i;
          virt_o   <= virt_i;
          ret_pc_o <= '0;
        end else begin
          mstat_o  <= mstat_n;
          hstat_o  <= hstat_n;
          priv_o   <= priv_n;
          virt_o   <= virt_n;
          ret_pc_o <= tgt_pc;
          swap_o   <= swap_n;
        end
      end else begin
        exc_o   <= 1'b0;
        cause_o <= '0;
      end
    end
  end

endmodule

// File: rtl/trap_ret_seq_chk.sv
module trap_ret_seq_chk
  import trap_ret_pkg::*;
#(
  parameter int unsigned XLEN  = 64,
  parameter bit          HAS_C = 1'b0,
  parameter int unsigned PMP_W = 7
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             req_is_mret_i,
  input logic [1:0]       priv_i,
  input logic [XLEN-1:0]  mstat_i,
  input logic [XLEN-1:0]  hstat_i,
  input logic [XLEN-1:0]  sepc_i,
  input logic [XLEN-1:0]  mepc_i,
  input logic [PMP_W-1:0] pmp_rules_i,
  input logic             done_o,
  input logic             exc_o,
  input logic [4:0]       cause_o,
  input logic [XLEN-1:0]  mstat_o,
  input logic [XLEN-1:0]  hstat_o,
  input logic [1:0]       priv_o,
  input logic             swap_o
);

  assert_req_done_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> done_o);
  assert_idle_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !done_o && !swap_o);
  assert_sret_user_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !req_is_mret_i && priv_i == PRIV_U |=> exc_o && cause_o == CAUSE_ILLEGAL);
  assert_sret_tsr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !req_is_mret_i && priv_i == PRIV_S && sepc_i[1:0] == 2'b00 && mstat_i[MS_TSR]
    |=> exc_o && cause_o == CAUSE_ILLEGAL);
  assert_mret_priv_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_is_mret_i && priv_i != PRIV_M |=> exc_o && cause_o == CAUSE_ILLEGAL);
  assert_mret_pmp_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_is_mret_i && priv_i == PRIV_M && mepc_i[1:0] == 2'b00 &&
    pmp_rules_i == '0 && mstat_i[MS_MPP_HI:MS_MPP_LO] != PRIV_M
    |=> exc_o && cause_o == CAUSE_ILLEGAL);
  assert_mret_fields_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_is_mret_i |=> exc_o ||
      (mstat_o[MS_MPP_HI:MS_MPP_LO] == PRIV_U && !mstat_o[MS_MPV] && mstat_o[MS_MPIE]));
  assert_sret_priv_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !req_is_mret_i |=> exc_o ||
      (priv_o == {1'b0, $past(mstat_i[MS_SPP])} && !mstat_o[MS_SPP] && mstat_o[MS_SPIE]));
  assert_exc_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> !exc_o || (!swap_o && mstat_o == $past(mstat_i) && hstat_o == $past(hstat_i)));

  generate
    if (!HAS_C) begin : g_align
      assert_sret_misal_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_valid_i && !req_is_mret_i && priv_i != PRIV_U && sepc_i[1:0] != 2'b00
        |=> exc_o && cause_o == CAUSE_MISALIGN);
    end
  endgenerate

endmodule

bind trap_ret_seq trap_ret_seq_chk #(.XLEN(XLEN), .HAS_C(HAS_C), .PMP_W(PMP_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_is_mret_i(req_is_mret_i),
  .priv_i(priv_i), .mstat_i(mstat_i), .hstat_i(hstat_i), .sepc_i(sepc_i), .mepc_i(mepc_i),
  .pmp_rules_i(pmp_rules_i), .done_o(done_o), .exc_o(exc_o), .cause_o(cause_o),
  .mstat_o(mstat_o), .hstat_o(hstat_o), .priv_o(priv_o), .swap_o(swap_o)
);

// File: tb/sim_trap_ret_seq.sv
`timescale 1ns/1ps
module sim_trap_ret_seq;

  localparam int XL = 64;

  typedef struct {
    logic          exc;
    logic [4:0]    cause;
    logic [XL-1:0] ms;
    logic [XL-1:0] hs;
    logic [1:0]    priv;
    logic          virt;
    logic [XL-1:0] pc;
    logic          swap;
    string         tag;
  } exp_t;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_valid_i = 1'b0, req_is_mret_i = 1'b0, virt_i = 1'b0;
  logic [1:0]    priv_i = 2'd0;
  logic [XL-1:0] mstat_i = '0, hstat_i = '0, sepc_i = '0, mepc_i = '0;
  logic [6:0]    pmp_rules_i = '0;
  logic          done_o, exc_o, virt_o, swap_o;
  logic [4:0]    cause_o;
  logic [XL-1:0] mstat_o, hstat_o, ret_pc_o;
  logic [1:0]    priv_o;

  int unsigned n_chk = 0, n_fail = 0;
  bit          finished = 1'b0;
  exp_t        sb[$];

  localparam logic [XL-1:0] MBASE = 64'hF0F0_0000_0000_0001;
  localparam logic [XL-1:0] HBASE = 64'h0000_0300_0000_0010;

  always #2.5 clk_i = ~clk_i;

  trap_ret_seq u0 (
    .clk_i, .rst_ni, .req_valid_i, .req_is_mret_i, .priv_i, .virt_i,
    .mstat_i, .hstat_i, .sepc_i, .mepc_i, .pmp_rules_i,
    .done_o, .exc_o, .cause_o, .mstat_o, .hstat_o, .priv_o, .virt_o, .ret_pc_o, .swap_o
  );

  function automatic exp_t model(logic mret, logic [1:0] pv, logic vt, logic [XL-1:0] ms,
                                 logic [XL-1:0] hs, logic [XL-1:0] se, logic [XL-1:0] me,
                                 logic [6:0] pmp, string tag);
    exp_t e;
    e.tag = tag; e.exc = 1'b0; e.cause = 5'd0;
    if (!mret) begin
      if (pv == 2'd0)                    begin e.exc = 1; e.cause = 5'd2;  end
      else if (se[1:0] != 0)             begin e.exc = 1; e.cause = 5'd0;  end
      else if (ms[22] && pv != 2'd3)     begin e.exc = 1; e.cause = 5'd2;  end
      else if (vt && hs[22])             begin e.exc = 1; e.cause = 5'd22; end
    end else begin
      if (pv != 2'd3)                          begin e.exc = 1; e.cause = 5'd2; end
      else if (me[1:0] != 0)                   begin e.exc = 1; e.cause = 5'd0; end
      else if (pmp == 0 && ms[12:11] != 2'd3)  begin e.exc = 1; e.cause = 5'd2; end
    end
    if (e.exc) begin
      e.ms = ms; e.hs = hs; e.priv = pv; e.virt = vt; e.pc = '0; e.swap = 0;
    end else if (!mret) begin
      e.ms = ms; e.hs = hs; e.pc = se; e.priv = {1'b0, ms[8]};
      e.ms[1] = ms[5]; e.ms[5] = 1'b1; e.ms[8] = 1'b0;
      if (!vt) begin e.virt = hs[7]; e.swap = hs[7]; e.hs[7] = 1'b0; end
      else     begin e.virt = 1'b1; e.swap = 1'b0; end
    end else begin
      e.ms = ms; e.hs = hs; e.pc = me; e.priv = ms[12:11];
      e.virt = ms[39]; e.swap = ms[39];
      e.ms[3] = ms[7]; e.ms[7] = 1'b1; e.ms[12:11] = 2'd0; e.ms[39] = 1'b0;
    end
    return e;
  endfunction

  task automatic send(logic mret, logic [1:0] pv, logic vt, logic [XL-1:0] ms,
                      logic [XL-1:0] hs, logic [XL-1:0] se, logic [XL-1:0] me,
                      logic [6:0] pmp, string tag);
    sb.push_back(model(mret, pv, vt, ms, hs, se, me, pmp, tag));
    req_valid_i = 1'b1; req_is_mret_i = mret; priv_i = pv; virt_i = vt;
    mstat_i = ms; hstat_i = hs; sepc_i = se; mepc_i = me; pmp_rules_i = pmp;
    @(negedge clk_i);
    req_valid_i = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  // monitor / scoreboard
  always @(negedge clk_i) begin
    if (rst_ni && done_o) begin
      exp_t e;
      n_chk++;
      if (sb.size() == 0) begin
        n_fail++;
        $display("FAIL R2: unexpected done_o, actual 1 expected 0");
      end else begin
        e = sb.pop_front();
        if (exc_o !== e.exc || cause_o !== e.cause || mstat_o !== e.ms || hstat_o !== e.hs ||
            priv_o !== e.priv || virt_o !== e.virt || ret_pc_o !== e.pc || swap_o !== e.swap) begin
          n_fail++;
          $display("FAIL %s: actual exc=%0b cause=%0d ms=%h hs=%h priv=%0d virt=%0b pc=%h swap=%0b expected exc=%0b cause=%0d ms=%h hs=%h priv=%0d virt=%0b pc=%h swap=%0b",
                   e.tag, exc_o, cause_o, mstat_o, hstat_o, priv_o, virt_o, ret_pc_o, swap_o,
                   e.exc, e.cause, e.ms, e.hs, e.priv, e.virt, e.pc, e.swap);
        end
      end
    end
  end

  task automatic check_quiet(string tag);
    n_chk++;
    if (done_o !== 1'b0 || swap_o !== 1'b0 || sb.size() != 0) begin
      n_fail++;
      $display("FAIL %s: actual done=%0b swap=%0b pending=%0d expected 0 0 0",
               tag, done_o, swap_o, sb.size());
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #100000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    idle(3);
    // R1 during reset
    n_chk++;
    if (done_o !== 0 || exc_o !== 0 || swap_o !== 0 || priv_o !== 2'd3 || virt_o !== 0 || cause_o !== 0) begin
      n_fail++;
      $display("FAIL R1: actual done=%0b exc=%0b swap=%0b priv=%0d virt=%0b expected 0 0 0 3 0",
               done_o, exc_o, swap_o, priv_o, virt_o);
    end
    rst_ni = 1'b1;
    idle(2);
    check_quiet("R1");

    // R3: user SRET
    send(0, 2'd0, 0, MBASE, HBASE, 64'h1000, 64'h2000, 7'd4, "R3");
    // R4: misaligned SRET target
    send(0, 2'd1, 0, MBASE, HBASE, 64'h1002, 64'h2000, 7'd4, "R4");
    // R8: user + misaligned -> illegal
    send(0, 2'd0, 0, MBASE, HBASE, 64'h1001, 64'h2000, 7'd4, "R8");
    // R5: TSR at supervisor, then at machine (no effect)
    send(0, 2'd1, 0, MBASE | (64'd1 << 22), HBASE, 64'h1000, 64'h2000, 7'd4, "R5");
    send(0, 2'd3, 0, MBASE | (64'd1 << 22) | (64'd1 << 5), HBASE, 64'h1100, 64'h2000, 7'd4, "R5");
    // R8: misaligned + TSR -> misaligned
    send(0, 2'd1, 0, MBASE | (64'd1 << 22), HBASE, 64'h1003, 64'h2000, 7'd4, "R8");
    // R6: VTSR with virt on, then off (no effect)
    send(0, 2'd1, 1, MBASE, HBASE | (64'd1 << 22), 64'h1000, 64'h2000, 7'd4, "R6");
    send(0, 2'd1, 0, MBASE, HBASE | (64'd1 << 22), 64'h1200, 64'h2000, 7'd4, "R6");
    idle(1);
    check_quiet("R2");
    // R9/R10: SPV=1 SPP=1 SPIE=1 SIE=0
    send(0, 2'd1, 0, MBASE | (64'd1 << 8) | (64'd1 << 5), HBASE | (64'd1 << 7), 64'h1300, 64'h2000, 7'd4, "R10");
    idle(1);
    check_quiet("R10");
    // R9: SPP=0 SPIE=0 SIE=1, SPV=0
    send(0, 2'd1, 0, MBASE | (64'd1 << 1), HBASE, 64'h1400, 64'h2000, 7'd4, "R9");
    // R10: virt on, SPV set -> stays virtual, no swap
    send(0, 2'd1, 1, MBASE | (64'd1 << 5), HBASE | (64'd1 << 7), 64'h1500, 64'h2000, 7'd4, "R10");
    // R7: MRET below machine
    send(1, 2'd1, 0, MBASE | (64'd3 << 11), HBASE, 64'h1000, 64'h2000, 7'd4, "R7");
    // R4: MRET misaligned
    send(1, 2'd3, 0, MBASE | (64'd3 << 11), HBASE, 64'h1000, 64'h2002, 7'd4, "R4");
    // R7: no rules, MPP=S
    send(1, 2'd3, 0, MBASE | (64'd1 << 11), HBASE, 64'h1000, 64'h2000, 7'd0, "R7");
    // R8: no rules + misaligned -> misaligned
    send(1, 2'd3, 0, MBASE | (64'd1 << 11), HBASE, 64'h1000, 64'h2001, 7'd0, "R8");
    // R7: no rules, MPP=M allowed
    send(1, 2'd3, 0, MBASE | (64'd3 << 11) | (64'd1 << 3), HBASE, 64'h1000, 64'h2100, 7'd0, "R7");
    // R11: MPV=1 MPP=S MPIE=0 MIE=1
    send(1, 2'd3, 0, MBASE | (64'd1 << 39) | (64'd1 << 11) | (64'd1 << 3), HBASE, 64'h1000, 64'h2200, 7'd4, "R11");
    // R11: MPV=0 MPP=U MPIE=1 MIE=0
    send(1, 2'd3, 0, MBASE | (64'd1 << 7), HBASE, 64'h1000, 64'h2300, 7'd4, "R11");
    idle(1);
    // R12: exception with SPV set must not swap or clear
    send(0, 2'd0, 0, MBASE | (64'd1 << 5), HBASE | (64'd1 << 7), 64'h1000, 64'h2000, 7'd4, "R12");
    idle(2);
    check_quiet("R2");
    finish_run();
  end

endmodule